// File: doc/BRIEF.md
# Binary to Decimal ASCII Converter

This block turns an unsigned 32-bit integer into a decimal text string ending in a zero byte. A `start` pulse captures the value. The block then divides the value by ten again and again. The remainder of each division becomes one ASCII digit, and the quotient becomes the value for the next division. The division is a bit-serial restoring divide by a constant ten and takes 32 clock cycles. Each digit therefore costs 33 cycles: 32 to divide and one to write.

The result leaves through a byte-write port into an 11-byte buffer owned by the host. The block writes the terminating zero byte first, at the highest offset. The digits come out least significant first, and each one lands one offset lower than the byte before it, so the finished string reads forward from its first character. When the block finishes, it raises `done` and reports the digit count and the offset of the first character. Both stay stable until the next `start`.

Top module: `dec_ascii_conv`

## Requirements
- R1: After reset, `done` and `wr_en` are 0 and `digit_cnt` is 0.
- R2: A `start` sampled while idle or done is accepted. The first write of the new conversion comes in the next cycle and stores 0x00 at offset 10.
- R3: Each digit is the remainder of the current value divided by ten, written as `0x30 | remainder`. Digits come out least significant first, at offsets 9, 8, 7, and so on downward.
- R4: Division repeats until the quotient is zero, so at least one digit is always produced. An input of 0 yields the single character 0x30 at offset 9.
- R5: While `done` is high, `digit_cnt` equals the number of digits and `first_off` equals 10 minus that count.
- R6: The input 4294967295 produces exactly 10 digits, and `first_off` is 0.
- R7: At most one byte is written per cycle. For an n-digit result, `done` becomes visible after the (1+33n)-th rising edge following the edge that samples `start`.
- R8: A `start` pulse during a conversion is ignored. The result and the timing of the running conversion are unchanged.
- R9: `done` stays high, with no byte writes, until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a conversion of `value` |
| value | input | 32 | Unsigned integer to convert |
| wr_en | output | 1 | Byte write strobe |
| wr_addr | output | 4 | Buffer offset of the byte being written |
| wr_data | output | 8 | Byte being written |
| digit_cnt | output | 4 | Number of digits in the finished string |
| first_off | output | 4 | Offset of the first character of the string |
| done | output | 1 | Conversion complete; results are valid |

## Verification
Two events can meet in one cycle: a new `start` can arrive while the divider is still running, and a new `start` can arrive in the same cycle that `done` is being held.

The bench provokes the first case by pulsing `start` with a different value in the middle of a conversion. It then checks that the buffer contents, the digit count and the completion cycle all match the original value.

It provokes the second case by issuing back-to-back conversions straight from the done state. It checks that the zero byte of the new string is written in the very next cycle and that the previous results are replaced.

// File: rtl/dec_ascii_conv.sv
module dec_ascii_conv #(
  parameter int VAL_W  = 32,
  parameter int DIGITS = 10,
  parameter int AW     = $clog2(DIGITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VAL_W-1:0] value,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [7:0]       wr_data,
  output logic [AW-1:0]    digit_cnt,
  output logic [AW-1:0]    first_off,
  output logic             done
);

  localparam int CW = $clog2(VAL_W);
  localparam logic [AW-1:0] END_OFF = AW'(DIGITS);

  typedef enum logic [2:0] {S_IDLE, S_NUL, S_DIV, S_PUT, S_DONE} st_t;

  st_t              st;
  logic [VAL_W-1:0] quo;
  logic [3:0]       rem;
  logic [CW-1:0]    step;
  logic [AW-1:0]    ptr;

  logic [4:0] trial;
  logic       fits;
  assign trial = {rem, quo[VAL_W-1]};
  assign fits  = trial >= 5'd10;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      quo  <= '0;
      rem  <= '0;
      step <= '0;
      ptr  <= END_OFF;
    end else begin
      case (st)
        S_IDLE, S_DONE: if (start) begin
          quo <= value;
          rem <= '0;
          ptr <= END_OFF;
          st  <= S_NUL;
        end
        S_NUL: begin
          step <= '0;
          st   <= S_DIV;
        end
        S_DIV: begin
          quo  <= {quo[VAL_W-2:0], fits};
          rem  <= fits ? 4'(trial - 5'd10) : trial[3:0];
          step <= step + 1'b1;
          if (step == CW'(VAL_W - 1)) st <= S_PUT;
        end
        S_PUT: begin
          ptr  <= ptr - 1'b1;
          rem  <= '0;
          step <= '0;
          st   <= (quo == '0) ? S_DONE : S_DIV;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign wr_en     = (st == S_NUL) || (st == S_PUT);
  assign wr_addr   = (st == S_NUL) ? END_OFF : ptr - 1'b1;
  assign wr_data   = (st == S_PUT) ? {4'h3, rem} : 8'h00;
  assign digit_cnt = END_OFF - ptr;
  assign first_off = ptr;
  assign done      = (st == S_DONE);

  // R3
  rem_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PUT) |-> (rem < 4'd10));

  // R3
  ascii_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != END_OFF) |-> (wr_data[7:4] == 4'h3 && wr_data[3:0] <= 4'd9));

  // R5
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (digit_cnt >= 1 && digit_cnt <= AW'(DIGITS)));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(first_off)));

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en);

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DIV || st == S_PUT) |=> (st != S_NUL));

endmodule

// File: tb/dec_ascii_conv_test.sv
module dec_ascii_conv_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [31:0] value = '0;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [3:0]  digit_cnt;
  logic [3:0]  first_off;
  logic        done;

  int checks = 0;
  int fails  = 0;

  logic [7:0] mem [0:10];
  logic [3:0] seq_a [0:31];
  logic [7:0] seq_d [0:31];
  int         nwr = 0;
  int         multi = 0;

  always #10 clk = ~clk;

  dec_ascii_conv uut (
    .clk(clk), .rst_n(rst_n), .start(start), .value(value),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .digit_cnt(digit_cnt), .first_off(first_off), .done(done)
  );

  always @(negedge clk) begin
    if (wr_en) begin
      if (wr_addr <= 4'd10) mem[wr_addr] = wr_data;
      if (nwr < 32) begin
        seq_a[nwr] = wr_addr;
        seq_d[nwr] = wr_data;
      end
      nwr = nwr + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i <= 10; i++) mem[i] = 8'hFF;
    nwr = 0;
  endtask

  task automatic expect_result(input logic [31:0] v, input int lat, input string tag);
    int d [0:9];
    int n;
    longint t;
    n = 0;
    t = v;
    do begin
      d[n] = int'(t % 10);
      t = t / 10;
      n++;
    end while (t != 0);
    chk(lat == 1 + 33 * n, "R7", {tag, " done latency"}, lat, 1 + 33 * n);
    chk(nwr == n + 1, "R7", {tag, " write count"}, nwr, n + 1);
    chk(seq_a[0] == 4'd10 && seq_d[0] == 8'h00, "R2", {tag, " zero byte first"},
        {seq_a[0], seq_d[0]}, {4'd10, 8'h00});
    for (int i = 0; i < n; i++) begin
      chk(seq_a[i+1] == 4'(9 - i), "R3", {tag, " write offset"}, seq_a[i+1], 9 - i);
      chk(seq_d[i+1] == 8'(8'h30 | d[i]), "R3", {tag, " digit byte"}, seq_d[i+1], 8'h30 | d[i]);
    end
    chk(mem[10] == 8'h00, "R2", {tag, " terminator in buffer"}, mem[10], 0);
    chk(digit_cnt == 4'(n), "R5", {tag, " digit_cnt"}, digit_cnt, n);
    chk(first_off == 4'(10 - n), "R5", {tag, " first_off"}, first_off, 10 - n);
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (!done && lat < 2000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_conv(input logic [31:0] v, input string tag);
    int lat;
    clear_model();
    value = v;
    start = 1;
    @(negedge clk);
    start = 0;
    wait_done(lat);
    expect_result(v, lat, tag);
  endtask

  task automatic run_intrude(input logic [31:0] v, input logic [31:0] other);
    int lat;
    clear_model();
    value = v;
    start = 1;
    @(negedge clk);
    start = 0;
    lat = 0;
    repeat (40) begin @(negedge clk); lat++; end
    value = other;
    start = 1;
    @(negedge clk);
    lat++;
    start = 0;
    value = '0;
    begin
      int rest;
      wait_done(rest);
      lat += rest;
    end
    expect_result(v, lat, "R8 busy start");
  endtask

  task automatic hold_check();
    repeat (5) @(negedge clk);
    chk(done == 1'b1, "R9", "done held", done, 1);
    chk(nwr == 0, "R9", "no writes while done", nwr, 0);
  endtask

  always @(negedge clk) if (wr_en && done) multi++;

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    chk(wr_en == 1'b0, "R1", "wr_en after reset", wr_en, 0);
    chk(digit_cnt == 4'd0, "R1", "digit_cnt after reset", digit_cnt, 0);
    rst_n = 1;
    @(negedge clk);
    run_conv(32'd2037, "R3 example");
    run_conv(32'd0, "R4 zero");
    run_conv(32'd9, "R4 one digit");
    run_conv(32'd10, "R4 ten");
    run_conv(32'd4294967295, "R6 max");
    chk(first_off == 4'd0, "R6", "max first_off", first_off, 0);
    run_conv(32'd1000000000, "R3 zeros inside");
    clear_model();
    hold_check();
    run_conv(32'd99, "R2 restart from done");
    run_intrude(32'd58301, 32'd7);
    chk(multi == 0, "R9", "writes seen while done", multi, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule